// File: doc/BRIEF.md
# Programmable Reset Pulse Generator

This block produces an active-high reset for the rest of a chip. It watches a flag that reports the main supply below its trip level, and a manual-reset request. While either is raised the reset output is high. When both have cleared, the output stays high for a stretch time and then drops. A two-bit select input chooses one of four stretch times, so the length can change at run time. Any new request during the stretch starts the count again from zero.

The supply flag and the manual request are asynchronous. Each one passes through its own two-flop synchronizer before it reaches the stretch counter. Next to the reset path there is a group of auxiliary comparator flags. Each flag goes straight to an output with no delay. A status register also captures the flags on every clock edge, so other logic can read their state.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `rst_o` is high and `stat_o` is zero. After `rst_n` rises, with no request present, `rst_o` falls at the L-th rising edge. L is the stretch length that `tsel_i` selects.
- R2: A high on `supply_low_i` drives `rst_o` high after the third rising edge that samples it. `rst_o` is still low after the second such edge. It stays high for as long as the flag stays high.
- R3: After `supply_low_i` returns low, `rst_o` falls exactly at the (L+2)-th rising edge. The count includes the first edge that samples the flag low.
- R4: A high on `man_rst_i` forces `rst_o` high with the same latency as R2. After the request returns low, `rst_o` falls at the (L+2)-th rising edge, counted as in R3.
- R5: A new supply request that arrives during a stretch restarts the count. When that request ends, the full (L+2)-edge stretch runs again.
- R6: The encoding of `tsel_i` is 2'b00→STRETCH0, 2'b01→STRETCH1, 2'b10→STRETCH2, 2'b11→STRETCH3. Each value is a number of clock cycles.
- R7: `aux_o` is equal to `aux_i` in the same cycle, with no register in the path.
- R8: On every rising edge out of reset, `stat_o` captures `aux_i`. The new value is visible right after that edge.
- R9: When the supply and manual requests overlap, `rst_o` stays high until the later of the two ends. It then falls (L+2) edges after that one is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| supply_low_i | input | 1 | Asynchronous flag, high while the supply is below its trip level |
| man_rst_i | input | 1 | Asynchronous manual-reset request, active high |
| tsel_i | input | 2 | Stretch-time select |
| aux_i | input | AUX_N | Synchronous auxiliary comparator flags, high when above trip |
| rst_o | output | 1 | Active-high reset output |
| aux_o | output | AUX_N | Undelayed copy of the auxiliary flags |
| stat_o | output | AUX_N | Registered status of the auxiliary flags |

## Verification
The bench builds the block with stretch lengths of 3, 6, 11 and 20 cycles. With such short lengths, all four select codes can be measured edge by edge in a short run. The lengths are also far enough apart that a wrong code mapping, or an off-by-one in the terminal count, gives a different count. The bench uses two auxiliary flags and two synchronizer stages. With these values, the restart and overlap cases fall within a few tens of cycles, and the fixed two-edge synchronizer latency is visible as its own part of the total count.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
   localparam int unsigned TSEL_W = 2;
   typedef logic [TSEL_W-1:0] tsel_t;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rpg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rpg_stretch.sv
module rpg_stretch
   import rpg_pkg::*;
#(
   parameter int unsigned STRETCH0 = 100,
   parameter int unsigned STRETCH1 = 1000,
   parameter int unsigned STRETCH2 = 10000,
   parameter int unsigned STRETCH3 = 100000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  hold_i,
   input  tsel_t tsel_i,
   output logic  busy_o
);
   localparam int unsigned MAXC = max4(STRETCH0, STRETCH1, STRETCH2, STRETCH3);
   localparam int unsigned CW   = $clog2(MAXC + 1);

   generate
      if (STRETCH0 < 1 || STRETCH1 < 1 || STRETCH2 < 1 || STRETCH3 < 1) begin : g_bad
         $error("rpg_stretch: every stretch length must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_m1;
   logic          busy_q;

   always_comb begin
      unique case (tsel_i)
         2'b00:   lim_m1 = CW'(STRETCH0 - 1);
         2'b01:   lim_m1 = CW'(STRETCH1 - 1);
         2'b10:   lim_m1 = CW'(STRETCH2 - 1);
         default: lim_m1 = CW'(STRETCH3 - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (hold_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q >= lim_m1) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;

   // R2 / R5: a live request always leaves the output asserted.
   assert_hold_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> busy_q);
   // R3: the output only releases after a quiet cycle.
   assert_fall_needs_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> !$past(hold_i));
   // R5: a stretch that has not reached its limit keeps going.
   assert_stretch_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !hold_i && cnt_q < lim_m1) |=> busy_q);
   // R6: the counter never runs past the longest setting.
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(MAXC));
endmodule

// File: rtl/rpg_status.sv
module rpg_status #(
   parameter int unsigned AUX_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AUX_N-1:0] aux_i,
   output logic [AUX_N-1:0] stat_o
);
   generate
      if (AUX_N < 1) begin : g_bad
         $error("rpg_status: AUX_N must be at least 1");
      end
   endgenerate

   logic [AUX_N-1:0] stat_q;

   generate
      for (genvar i = 0; i < AUX_N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= aux_i[i];
         end
      end
   endgenerate

   assign stat_o = stat_q;

   // R8: the status bits reflect the flags of the previous edge.
   assert_stat_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> stat_q == $past(aux_i));
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
   import rpg_pkg::*;
#(
   parameter int unsigned AUX_N       = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STRETCH0    = 100,
   parameter int unsigned STRETCH1    = 1000,
   parameter int unsigned STRETCH2    = 10000,
   parameter int unsigned STRETCH3    = 100000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_low_i,
   input  logic             man_rst_i,
   input  logic [1:0]       tsel_i,
   input  logic [AUX_N-1:0] aux_i,
   output logic             rst_o,
   output logic [AUX_N-1:0] aux_o,
   output logic [AUX_N-1:0] stat_o
);
   logic sup_s;
   logic man_s;
   logic hold;

   rpg_sync #(.STAGES(SYNC_STAGES)) u_sync_sup (
      .clk(clk), .rst_n(rst_n), .din(supply_low_i), .dout(sup_s));

   rpg_sync #(.STAGES(SYNC_STAGES)) u_sync_man (
      .clk(clk), .rst_n(rst_n), .din(man_rst_i), .dout(man_s));

   assign hold = sup_s | man_s;

   rpg_stretch #(
      .STRETCH0(STRETCH0), .STRETCH1(STRETCH1),
      .STRETCH2(STRETCH2), .STRETCH3(STRETCH3)
   ) u_stretch (
      .clk(clk), .rst_n(rst_n), .hold_i(hold), .tsel_i(tsel_t'(tsel_i)), .busy_o(rst_o));

   rpg_status #(.AUX_N(AUX_N)) u_status (
      .clk(clk), .rst_n(rst_n), .aux_i(aux_i), .stat_o(stat_o));

   assign aux_o = aux_i;

   // R4: a synchronized manual request keeps the reset output high.
   assert_man_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
      man_s |=> rst_o);
endmodule

// File: tb/sim_rst_pulse_gen.sv
module sim_rst_pulse_gen;
   localparam int CLK_PERIOD = 10;
   localparam int S0 = 3, S1 = 6, S2 = 11, S3 = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sup = 1'b0;
   logic       man = 1'b0;
   logic [1:0] tsel = 2'b00;
   logic [1:0] aux = 2'b00;
   logic       rst_o;
   logic [1:0] aux_o, stat_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_pulse_gen #(.AUX_N(2), .SYNC_STAGES(2), .STRETCH0(S0), .STRETCH1(S1),
                   .STRETCH2(S2), .STRETCH3(S3)) u0 (
      .clk(clk), .rst_n(rst_n), .supply_low_i(sup), .man_rst_i(man), .tsel_i(tsel),
      .aux_i(aux), .rst_o(rst_o), .aux_o(aux_o), .stat_o(stat_o));

   function automatic int len_of(input logic [1:0] s);
      case (s)
         2'b00: return S0;
         2'b01: return S1;
         2'b10: return S2;
         default: return S3;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // counts rising edges until rst_o is seen low at a falling edge
   task automatic edges_to_fall(output int n);
      n = 0;
      forever begin
         @(posedge clk); n++;
         @(negedge clk);
         if (!rst_o || n > 300) break;
      end
   endtask

   task automatic do_reset(input logic [1:0] s);
      @(negedge clk);
      rst_n = 1'b0; sup = 1'b0; man = 1'b0; tsel = s;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset(input logic [1:0] s);
      int n;
      do_reset(s);
      aux = 2'b11;
      #1;
      check("R1 rst_o during reset", rst_o, 1);
      check("R1 stat_o during reset", stat_o, 0);
      aux = 2'b00;
      rst_n = 1'b1;
      edges_to_fall(n);
      check($sformatf("R1 R6 release stretch tsel=%0d", s), n, len_of(s));
   endtask

   task automatic t_supply(input logic [1:0] s);
      int n;
      do_reset(s);
      rst_n = 1'b1;
      edges_to_fall(n);
      sup = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R2 not yet high after 2 edges", rst_o, 0);
      @(posedge clk); @(negedge clk);
      check("R2 high after 3 edges", rst_o, 1);
      repeat (30) @(negedge clk);
      check("R2 held while flag high", rst_o, 1);
      sup = 1'b0;
      edges_to_fall(n);
      check($sformatf("R3 R6 stretch after supply tsel=%0d", s), n, len_of(s) + 2);
   endtask

   task automatic t_manual(input logic [1:0] s);
      int n;
      do_reset(s);
      rst_n = 1'b1;
      edges_to_fall(n);
      man = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R4 manual forces high", rst_o, 1);
      man = 1'b0;
      edges_to_fall(n);
      check("R4 stretch after manual", n, len_of(s) + 2);
   endtask

   task automatic t_restart();
      int n;
      do_reset(2'b11);
      rst_n = 1'b1;
      edges_to_fall(n);
      sup = 1'b1; repeat (4) @(negedge clk); sup = 1'b0;
      repeat (12) @(negedge clk);
      check("R5 still stretching mid count", rst_o, 1);
      sup = 1'b1; @(negedge clk); sup = 1'b0;
      edges_to_fall(n);
      check("R5 count restarted", n, S3 + 2);
   endtask

   task automatic t_overlap();
      int n;
      do_reset(2'b01);
      rst_n = 1'b1;
      edges_to_fall(n);
      sup = 1'b1; repeat (3) @(negedge clk);
      man = 1'b1; repeat (3) @(negedge clk);
      sup = 1'b0; repeat (10) @(negedge clk);
      check("R9 held by later request", rst_o, 1);
      man = 1'b0;
      edges_to_fall(n);
      check("R9 stretch after later request", n, S1 + 2);
   endtask

   task automatic t_aux();
      do_reset(2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      aux = 2'b10; #1;
      check("R7 passthrough same cycle", aux_o, 2'b10);
      check("R8 status not updated before edge", stat_o, 2'b00);
      @(posedge clk); #1;
      check("R8 status captured", stat_o, 2'b10);
      @(negedge clk);
      aux = 2'b01; #1;
      check("R7 passthrough second pattern", aux_o, 2'b01);
      @(posedge clk); #1;
      check("R8 status follows", stat_o, 2'b01);
   endtask

   initial begin
      for (int s = 0; s < 4; s++) t_reset(2'(s));
      t_supply(2'b00);
      t_supply(2'b10);
      t_manual(2'b01);
      t_manual(2'b11);
      t_restart();
      t_overlap();
      t_aux();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule